// File: doc/BRIEF.md
# Instruction trace view filter

This block makes a per-element trace decision for a stream of retired instructions and exceptions. Each cycle a valid element comes in with its exception level, its security state and a kind tag. The block answers on the same cycle with a single trace-enable bit. A downstream packet generator uses that bit to keep or drop the element. The resources it selects from are produced elsewhere. This block only picks one of them, or one OR-combined pair, as its view event.

Behaviour is set by one 32-bit control word. A simple register bus reads and writes it at a single offset. The word holds a disable mask of exception levels for each security state, the event selection, and two force bits. The force bits make reset and system-error exceptions always traced. A start/stop flag is driven by start and stop pulses, and its value reads back through the same word. A registered flag remembers whether the previous valid element was traced. Reset and system-error exceptions follow that flag unless their force bit is set.

Top module: `trace_view_filter`

## Requirements
- R1: The control word answers reads only at bus address 0x080; every other address reads 0. Bits [31:24], [15:12], [8] and [6:4] always read 0. After reset the word reads 0.
- R2: Bit 23 (Non-secure level 3) and bit 18 (Secure level 2) always read 0 and ignore writes. Elements at those levels are therefore never suppressed by the mask.
- R3: For a Non-secure element (`elem_nonsecure`=1) at level n in 0..2, bit 20+n set to 1 suppresses trace and 0 allows it.
- R4: For a Secure element (`elem_nonsecure`=0), bit 16 covers level 0, bit 17 covers level 1 and bit 19 covers level 3. The polarity is the same as in R3.
- R5: When bit 7 is 0, the view event is `res_vec[SEL]`, where SEL is bits [3:0] of the word.
- R6: When bit 7 is 1, the view event is pair p = bits [2:0]: `res_vec[2p] | res_vec[2p+1]`. Bit 3 is ignored in this mode.
- R7: A start pulse sets the start/stop flag and a stop pulse clears it. When both come in one cycle, the flag clears. The new value applies from the next cycle. The flag reads back at bit 9, and writes to bit 9 are ignored. The flag resets to 0 (stopped).
- R8: For a kind 0 (plain) or kind 3 (other exception) element, `trace_en` = event AND started AND level not masked. `trace_en` is 0 whenever `elem_valid` is 0.
- R9: For a kind 1 (reset exception) element, `trace_en` is 1 if bit 10 is 1. Otherwise `trace_en` equals the last-traced flag.
- R10: For a kind 2 (system-error exception) element, `trace_en` is 1 if bit 11 is 1. Otherwise `trace_en` equals the last-traced flag.
- R11: The last-traced flag resets to 0. On each valid element it takes that element's `trace_en`. It holds its value across cycles without a valid element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| ss_start | input | 1 | Start pulse |
| ss_stop | input | 1 | Stop pulse |
| elem_valid | input | 1 | An element retires this cycle |
| elem_level | input | 2 | Exception level of the element |
| elem_nonsecure | input | 1 | 1 = Non-secure, 0 = Secure |
| elem_kind | input | 2 | 0 plain, 1 reset exc., 2 system-error exc., 3 other exc. |
| res_vec | input | 16 | Resource vector |
| trace_en | output | 1 | Trace decision for the current element |

## Verification
Some rules are checked by assertions on every cycle. Reserved read bits stay zero. Stop wins over start, and start sets the flag. A forced reset or system-error exception is always traced. Nothing is traced while stopped or when no element is valid. The last-traced flag follows each valid decision and holds otherwise. Other behaviours can only be shown by the bench scenarios: the per-state level masks, the write-ignored bits 23, 18 and 9, single versus paired event selection with the unused SEL bit, and the reset and system-error exceptions following the previous decision across idle cycles.

// File: rtl/tvf_pkg.sv
package tvf_pkg;

    localparam int CTRL_W   = 32;
    localparam int NS_LSB   = 20;
    localparam int S_LSB    = 16;
    localparam int SERR_BIT = 11;
    localparam int RST_BIT  = 10;
    localparam int SS_BIT   = 9;
    localparam int TYPE_BIT = 7;
    localparam int SEL_LSB  = 0;

    // writable bits: NS mask [22:20], S mask 19,17,16, force bits 11,10, type 7, sel [3:0]
    localparam logic [CTRL_W-1:0] WR_MASK   = 32'h007B_0C8F;
    localparam logic [CTRL_W-1:0] READ_MASK = WR_MASK | (32'h1 << SS_BIT);

    typedef enum logic [1:0] {
        ELEM_PLAIN  = 2'd0,
        ELEM_RESET  = 2'd1,
        ELEM_SERROR = 2'd2,
        ELEM_OTHER  = 2'd3
    } elem_kind_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              started;
    } ctrl_state_t;

    typedef struct packed {
        logic last_traced;
    } decide_state_t;

endpackage

// File: rtl/tvf_ctrl_reg.sv
module tvf_ctrl_reg
    import tvf_pkg::*;
#(
    parameter int              ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'h080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CTRL_W-1:0] bus_wdata,
    output logic [CTRL_W-1:0] bus_rdata,
    input  logic              ss_start,
    input  logic              ss_stop,
    output logic [3:0]        ns_mask_o,
    output logic [3:0]        s_mask_o,
    output logic              force_rst_o,
    output logic              force_serr_o,
    output logic              pair_mode_o,
    output logic [3:0]        sel_o,
    output logic              started_o
);

    ctrl_state_t r_d, r_q;
    logic        hit;

    assign hit = (bus_addr == CTRL_OFFSET);

    always_comb begin
        r_d = r_q;
        if (hit && bus_wr) begin
            r_d.ctrl = bus_wdata & WR_MASK;
        end
        if (ss_stop) begin
            r_d.started = 1'b0;
        end else if (ss_start) begin
            r_d.started = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata = r_q.ctrl;
            bus_rdata[SS_BIT] = r_q.started;
        end
    end

    assign ns_mask_o    = r_q.ctrl[NS_LSB +: 4];
    assign s_mask_o     = r_q.ctrl[S_LSB +: 4];
    assign force_rst_o  = r_q.ctrl[RST_BIT];
    assign force_serr_o = r_q.ctrl[SERR_BIT];
    assign pair_mode_o  = r_q.ctrl[TYPE_BIT];
    assign sel_o        = r_q.ctrl[SEL_LSB +: 4];
    assign started_o    = r_q.started;

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~READ_MASK) == '0);

    assert_stop_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ss_stop |=> !started_o);

    assert_start_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_start && !ss_stop) |=> started_o);

    assert_unimpl_levels_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ns_mask_o[3] && !s_mask_o[2]);

endmodule

// File: rtl/tvf_event_sel.sv
module tvf_event_sel #(
    parameter int NUM_RES = 16
) (
    input  logic [NUM_RES-1:0]         res_vec,
    input  logic                       pair_mode,
    input  logic [$clog2(NUM_RES)-1:0] sel,
    output logic                       event_o
);

    localparam int NUM_PAIRS  = NUM_RES / 2;
    localparam int PAIR_SEL_W = $clog2(NUM_PAIRS);

    logic [NUM_PAIRS-1:0] pair_or;

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        assign pair_or[g] = res_vec[2*g] | res_vec[2*g+1];
    end

    always_comb begin
        if (pair_mode) begin
            event_o = pair_or[sel[PAIR_SEL_W-1:0]];
        end else begin
            event_o = res_vec[sel];
        end
    end

endmodule

// File: rtl/tvf_level_gate.sv
module tvf_level_gate (
    input  logic [3:0] ns_mask,
    input  logic [3:0] s_mask,
    input  logic [1:0] level,
    input  logic       nonsecure,
    output logic       allow_o
);

    logic [3:0] mask_sel;

    always_comb begin
        mask_sel = nonsecure ? ns_mask : s_mask;
        allow_o  = !mask_sel[level];
    end

endmodule

// File: rtl/tvf_decide.sv
module tvf_decide
    import tvf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       elem_valid,
    input  logic [1:0] elem_kind,
    input  logic       base_ok,
    input  logic       force_rst,
    input  logic       force_serr,
    output logic       trace_en
);

    decide_state_t s_d, s_q;
    elem_kind_e    kind;

    assign kind = elem_kind_e'(elem_kind);

    always_comb begin
        trace_en = 1'b0;
        if (elem_valid) begin
            unique case (kind)
                ELEM_RESET:  trace_en = force_rst  | s_q.last_traced;
                ELEM_SERROR: trace_en = force_serr | s_q.last_traced;
                default:     trace_en = base_ok;
            endcase
        end
        s_d = s_q;
        if (elem_valid) begin
            s_d.last_traced = trace_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !elem_valid |-> !trace_en);

    assert_forced_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && elem_kind == 2'd1 && force_rst) |-> trace_en);

    assert_forced_serror_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && elem_kind == 2'd2 && force_serr) |-> trace_en);

    assert_last_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid |=> (s_q.last_traced == $past(trace_en)));

    assert_last_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !elem_valid |=> $stable(s_q.last_traced));

endmodule

// File: rtl/trace_view_filter.sv
module trace_view_filter
    import tvf_pkg::*;
#(
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'h080,
    parameter int                NUM_RES     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               ss_start,
    input  logic               ss_stop,
    input  logic               elem_valid,
    input  logic [1:0]         elem_level,
    input  logic               elem_nonsecure,
    input  logic [1:0]         elem_kind,
    input  logic [NUM_RES-1:0] res_vec,
    output logic               trace_en
);

    localparam int SEL_W = $clog2(NUM_RES);

    logic [3:0] ns_mask, s_mask, sel;
    logic       force_rst, force_serr, pair_mode, started;
    logic       event_hit, level_ok, base_ok;

    tvf_ctrl_reg #(
        .ADDR_W      (ADDR_W),
        .CTRL_OFFSET (CTRL_OFFSET)
    ) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .ss_start     (ss_start),
        .ss_stop      (ss_stop),
        .ns_mask_o    (ns_mask),
        .s_mask_o     (s_mask),
        .force_rst_o  (force_rst),
        .force_serr_o (force_serr),
        .pair_mode_o  (pair_mode),
        .sel_o        (sel),
        .started_o    (started)
    );

    tvf_event_sel #(
        .NUM_RES (NUM_RES)
    ) i_event (
        .res_vec   (res_vec),
        .pair_mode (pair_mode),
        .sel       (sel[SEL_W-1:0]),
        .event_o   (event_hit)
    );

    tvf_level_gate i_level (
        .ns_mask   (ns_mask),
        .s_mask    (s_mask),
        .level     (elem_level),
        .nonsecure (elem_nonsecure),
        .allow_o   (level_ok)
    );

    assign base_ok = event_hit & started & level_ok;

    tvf_decide i_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .elem_valid (elem_valid),
        .elem_kind  (elem_kind),
        .base_ok    (base_ok),
        .force_rst  (force_rst),
        .force_serr (force_serr),
        .trace_en   (trace_en)
    );

    assert_stopped_plain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && !elem_kind[0] && !elem_kind[1] && !bus_rdata_started()) |-> !trace_en);

    function automatic logic bus_rdata_started();
        return started;
    endfunction

endmodule

// File: tb/test_trace_view_filter.sv
module test_trace_view_filter;

    localparam logic [31:0] WMASK = 32'h007B_0C8F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = 12'h080;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ss_start = 1'b0, ss_stop = 1'b0;
    logic        elem_valid = 1'b0;
    logic [1:0]  elem_level = '0;
    logic        elem_nonsecure = 1'b0;
    logic [1:0]  elem_kind = '0;
    logic [15:0] res_vec = '0;
    logic        trace_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] ctrl_m = '0;
    bit          ss_m = 1'b0;
    bit          last_m = 1'b0;

    always #10 clk = ~clk;

    trace_view_filter i_trace_view_filter (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_wr         (bus_wr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .ss_start       (ss_start),
        .ss_stop        (ss_stop),
        .elem_valid     (elem_valid),
        .elem_level     (elem_level),
        .elem_nonsecure (elem_nonsecure),
        .elem_kind      (elem_kind),
        .res_vec        (res_vec),
        .trace_en       (trace_en)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_trace(bit v, int lvl, bit ns, int kind, logic [15:0] res);
        bit ev, masked;
        int p;
        if (!v) return 1'b0;
        if (ctrl_m[7]) begin
            p = int'(ctrl_m[2:0]);
            ev = res[2*p] | res[2*p+1];
        end else begin
            ev = res[ctrl_m[3:0]];
        end
        masked = ctrl_m[(ns ? 20 : 16) + lvl];
        if (kind == 1) return ctrl_m[10] ? 1'b1 : last_m;
        if (kind == 2) return ctrl_m[11] ? 1'b1 : last_m;
        return ev && ss_m && !masked;
    endfunction

    task automatic step(string req, bit v, int lvl, bit ns, int kind,
                        logic [15:0] res, bit st, bit sp);
        bit e;
        @(negedge clk);
        elem_valid = v; elem_level = 2'(lvl); elem_nonsecure = ns;
        elem_kind = 2'(kind); res_vec = res; ss_start = st; ss_stop = sp;
        #2;
        e = exp_trace(v, lvl, ns, kind, res);
        check(req, {31'd0, trace_en}, {31'd0, e});
        @(posedge clk);
        #1;
        if (v) last_m = e;
        if (sp) ss_m = 1'b0;
        else if (st) ss_m = 1'b1;
        elem_valid = 1'b0; ss_start = 1'b0; ss_stop = 1'b0;
    endtask

    task automatic write_ctrl(logic [31:0] w);
        @(negedge clk);
        bus_addr = 12'h080; bus_wdata = w; bus_wr = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        ctrl_m = w & WMASK;
    endtask

    task automatic read_check(string req, logic [11:0] a);
        logic [31:0] e;
        @(negedge clk);
        bus_addr = a;
        #2;
        e = (a == 12'h080) ? (ctrl_m | (32'(ss_m) << 9)) : 32'h0;
        check(req, bus_rdata, e);
        bus_addr = 12'h080;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset value and address decode
        read_check("R1", 12'h080);
        read_check("R1", 12'h084);

        // R1 R2 reserved and unimplemented bits
        write_ctrl(32'hFFFF_FFFF);
        read_check("R1", 12'h080);
        read_check("R1", 12'h000);
        @(negedge clk);
        check("R2", {31'd0, bus_rdata[23]}, 32'd0);
        check("R2", {31'd0, bus_rdata[18]}, 32'd0);

        // R7 start/stop flag and read-back
        write_ctrl(32'h0);
        step("R7", 0, 0, 0, 0, 16'h0, 1, 0);
        read_check("R7", 12'h080);
        write_ctrl(32'h0000_0200);
        read_check("R7", 12'h080);
        step("R7", 0, 0, 0, 0, 16'h0, 1, 1);
        read_check("R7", 12'h080);
        step("R7", 1, 0, 0, 0, 16'h1, 0, 0);
        step("R7", 1, 0, 0, 0, 16'h1, 1, 0);
        step("R7", 1, 0, 0, 0, 16'h1, 0, 1);
        step("R7", 1, 0, 0, 0, 16'h1, 1, 0);

        // R8 main path
        step("R8", 1, 0, 0, 0, 16'h1, 0, 0);
        step("R8", 0, 0, 0, 0, 16'h1, 0, 0);
        step("R8", 1, 2, 1, 3, 16'h1, 0, 0);

        // R3 Non-secure mask, R4 Secure mask
        write_ctrl(32'h0020_0000);
        step("R3", 1, 1, 1, 0, 16'h1, 0, 0);
        step("R3", 1, 0, 1, 0, 16'h1, 0, 0);
        step("R4", 1, 1, 0, 0, 16'h1, 0, 0);
        write_ctrl(32'h0002_0000);
        step("R4", 1, 1, 0, 0, 16'h1, 0, 0);
        step("R3", 1, 1, 1, 0, 16'h1, 0, 0);
        write_ctrl(32'h0008_0000);
        step("R4", 1, 3, 0, 0, 16'h1, 0, 0);
        write_ctrl(32'h0004_0000);
        step("R2", 1, 2, 0, 0, 16'h1, 0, 0);
        write_ctrl(32'h0080_0000);
        step("R2", 1, 3, 1, 0, 16'h1, 0, 0);

        // R5 single resource, R6 pair
        write_ctrl(32'h0000_0005);
        step("R5", 1, 0, 0, 0, 16'h0020, 0, 0);
        step("R5", 1, 0, 0, 0, 16'h0010, 0, 0);
        write_ctrl(32'h0000_0083);
        step("R6", 1, 0, 0, 0, 16'h0080, 0, 0);
        step("R6", 1, 0, 0, 0, 16'h0040, 0, 0);
        step("R6", 1, 0, 0, 0, 16'h0100, 0, 0);
        write_ctrl(32'h0000_008B);
        step("R6", 1, 0, 0, 0, 16'h0080, 0, 0);
        step("R6", 1, 0, 0, 0, 16'h0800, 0, 0);

        // R9 R10 R11 previous-decision rules
        write_ctrl(32'h0);
        step("R11", 1, 0, 0, 0, 16'h0, 0, 0);
        step("R9", 1, 0, 0, 1, 16'h1, 0, 0);
        step("R11", 1, 0, 0, 0, 16'h1, 0, 0);
        step("R9", 1, 0, 0, 1, 16'h0, 0, 0);
        step("R11", 1, 0, 0, 0, 16'h0, 0, 0);
        step("R10", 1, 0, 0, 2, 16'h1, 0, 0);
        write_ctrl(32'h0000_0400);
        step("R9", 1, 0, 0, 1, 16'h0, 0, 0);
        write_ctrl(32'h0000_0800);
        step("R11", 1, 0, 0, 0, 16'h0, 0, 0);
        step("R10", 1, 0, 0, 2, 16'h0, 0, 0);
        write_ctrl(32'h0);
        step("R11", 1, 0, 0, 0, 16'h1, 0, 0);
        step("R11", 0, 0, 0, 0, 16'h0, 0, 0);
        step("R11", 0, 0, 0, 0, 16'h0, 0, 0);
        step("R10", 1, 0, 0, 2, 16'h0, 0, 0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int k;
            if (i % 64 == 0) begin
                write_ctrl($urandom());
                read_check("R1", 12'h080);
            end
            k = int'($urandom_range(0, 3));
            step(k == 1 ? "R9" : (k == 2 ? "R10" : "R8"),
                 $urandom_range(0, 3) != 0, int'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), k, 16'($urandom()),
                 $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
        end

        done = 1'b1;
        finish_run();
    end

endmodule